// File: doc/BRIEF.md
# SPI register access engine with CRC-8

This block is the host side of a byte-wide register link to a converter that sits on an SPI bus. A client hands it one request at a time over a valid/ready handshake: a write, a read, a read-modify-write or a software reset. The engine builds the command frame and adds a CRC-8 byte to protect it. It then drives chip select, serial clock and MOSI as an SPI mode-0 master and collects MISO. When the frame is over it reports the result with a single-cycle done pulse.

For a read, the engine recomputes the CRC over the command byte and the returned data byte, and flags a mismatch while still handing the data back. For a read-modify-write, it first reads the register, then merges the new bits under a mask. It sends the write frame only when the merged value differs from the old one and the read was clean. One configurable register address is exempt from CRC: its frames are two bytes long and carry no check. The software reset clocks out sixty-four ones and then holds off the done pulse for a settling time.

Top module: `spi_regacc`

## Requirements
- R1: A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_op_i` selects the operation: 0 write, 1 read, 2 read-modify-write, 3 software reset. The first byte shifted out is the command: bit 7 is 1 for a read and 0 for a write, and bits 6:0 carry `req_addr_i`. Every byte is sent MSB first.
- R2: A normal frame has three bytes: the command, then a data byte, then a check byte. The data byte is `req_wdata_i` on writes and 0x00 on reads. On a read, the second byte received on MISO is the register value.
- R3: The check byte is a CRC-8 over the command byte followed by the data byte. It uses polynomial 0x07, processes bits MSB first, starts from 0x00 and applies no final XOR.
- R4: Frames to address NOCRC_ADDR (default 0x5A) have two bytes and no check byte. A read of that address never reports a CRC error.
- R5: On a read, the engine computes the CRC of {command, received data byte} and compares it with the third received byte. A mismatch sets `crc_err_o`, and `rdata_o` still carries the received data byte.
- R6: A read-modify-write reads the register and computes new = (old & ~`req_mask_i`) | (`req_wdata_i` & `req_mask_i`). It sends a write frame of the new value only when new differs from old. `rdata_o` returns old.
- R7: A read-modify-write whose read frame fails the CRC check sends no write frame and reports `crc_err_o` = 1.
- R8: A software reset is one chip-select window of 64 SCLK periods with MOSI high throughout. Its done pulse comes at least RST_WAIT_CYC clock cycles after chip select rises.
- R9: SPI mode 0 applies. SCLK is low whenever chip select is high, and each SCLK high phase lasts exactly CLK_DIV clock cycles.
- R10: Chip select stays low for the whole frame. Between frames it stays high for at least 2·GAP_SCLK·CLK_DIV clock cycles.
- R11: `busy_o` is high from the cycle after acceptance until the operation ends, and `req_ready_o` is its inverse. A request offered while busy is ignored. After reset, `busy_o` is low, chip select is high and SCLK is low.
- R12: `done_o` is a one-cycle pulse in the first cycle with `busy_o` low. In that cycle `rdata_o` and `crc_err_o` are valid. Writes and resets return `rdata_o` = 0x00 and `crc_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle, request will be taken |
| req_op_i | input | 2 | Operation code |
| req_addr_i | input | 7 | Register address |
| req_wdata_i | input | 8 | Write data or merge value |
| req_mask_i | input | 8 | Merge mask for read-modify-write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Data read back |
| crc_err_o | output | 1 | Read CRC mismatch |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
Errors in internal state each show up at the ports in a different way:
- A wrong byte index or frame length changes the number of SCLK edges inside the chip-select window, and the bus model catches this when chip select rises.
- A stale command register or a bad CRC calculation corrupts the check byte of that same frame, or flips `crc_err_o` at the very next done pulse.
- A faulty merge or skip decision in the read-modify-write path shows up as an extra or missing write frame within one gap time of the read frame, and as the wrong register contents afterwards.
- Counter faults in the gap or reset wait shorten the chip-select high time or bring the done pulse early, and both are measured in clock cycles.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
  localparam int unsigned AW        = 7;
  localparam int unsigned DW        = 8;
  localparam int unsigned RST_BYTES = 8;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_RMW  = 2'd2,
    OP_SRST = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SHIFT,
    S_GAP,
    S_WAIT
  } st_e;
endpackage

// File: rtl/spi_regacc_crc8.sv
module spi_regacc_crc8 #(
  parameter int unsigned NBYTES = 2,
  parameter logic [7:0]  POLY   = 8'h07
) (
  input  logic [8*NBYTES-1:0] msg_i,
  output logic [7:0]          crc_o
);
  logic [7:0] c;
  logic       fb;

  always_comb begin
    c  = 8'h00;
    fb = 1'b0;
    for (int i = 8*NBYTES-1; i >= 0; i--) begin
      fb = c[7] ^ msg_i[i];
      c  = {c[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
    end
  end

  assign crc_o = c;
endmodule

// File: rtl/spi_regacc_shift.sv
module spi_regacc_shift #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active_q, sclk_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    txs_q, rxs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      txs_q    <= '0;
      rxs_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        txs_q    <= tx_i;
        cnt_q    <= '0;
        bit_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (cnt_q == CW'(CLK_DIV-1)) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rxs_q  <= {rxs_q[6:0], miso_i};  // sample on rising edge
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              txs_q <= {txs_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // present next byte's MSB while idle so MOSI is settled before first edge
  assign mosi_o = active_q ? txs_q[7] : tx_i[7];
  assign sclk_o = sclk_q;
  assign rx_o   = rxs_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
  import spi_regacc_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 4,
  parameter int unsigned GAP_SCLK     = 2,
  parameter int unsigned RST_WAIT_CYC = 28125,
  parameter logic [6:0]  NOCRC_ADDR   = 7'h5A,
  parameter logic [7:0]  CRC_POLY     = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] req_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          crc_err_o,
  output logic          sclk_o,
  output logic          cs_no,
  output logic          mosi_o,
  input  logic          miso_i
);
  localparam int unsigned GAP_CYC = GAP_SCLK * 2 * CLK_DIV;
  localparam int unsigned WMAX    = (RST_WAIT_CYC > GAP_CYC) ? RST_WAIT_CYC : GAP_CYC;
  localparam int unsigned WW      = $clog2(WMAX + 1);
  localparam int unsigned IW      = $clog2(RST_BYTES);

  st_e           st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wval_q, mask_q, rx_dat_q, rx_crc_q, rdata_q;
  logic          wr_ph_q, done_q, err_q;
  logic [IW-1:0] idx_q, last_idx;
  logic [WW-1:0] wcnt_q;

  logic          rd_ph, nocrc, crc_bad, sh_done;
  logic [7:0]    cmd, dbyte, crc_tx, crc_exp, tx_byte, sh_rx, merged;

  assign rd_ph   = (op_q == OP_RD) || (op_q == OP_RMW && !wr_ph_q);
  assign nocrc   = (addr_q == NOCRC_ADDR);
  assign cmd     = {rd_ph, addr_q};
  assign dbyte   = rd_ph ? 8'h00 : wval_q;
  assign merged  = (rx_dat_q & ~mask_q) | (wval_q & mask_q);
  assign crc_bad = !nocrc && (crc_exp != rx_crc_q);

  spi_regacc_crc8 #(.NBYTES(2), .POLY(CRC_POLY)) u_crc_tx (
    .msg_i ({cmd, dbyte}),
    .crc_o (crc_tx)
  );

  spi_regacc_crc8 #(.NBYTES(2), .POLY(CRC_POLY)) u_crc_rx (
    .msg_i ({cmd, rx_dat_q}),
    .crc_o (crc_exp)
  );

  always_comb begin
    if (op_q == OP_SRST)  last_idx = IW'(RST_BYTES - 1);
    else if (nocrc)       last_idx = IW'(1);
    else                  last_idx = IW'(2);
    if (op_q == OP_SRST)  tx_byte = 8'hFF;
    else if (idx_q == '0) tx_byte = cmd;
    else if (idx_q == IW'(1)) tx_byte = dbyte;
    else                  tx_byte = crc_tx;
  end

  spi_regacc_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (st_q == S_LOAD),
    .tx_i    (tx_byte),
    .rx_o    (sh_rx),
    .done_o  (sh_done),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      op_q     <= OP_WR;
      addr_q   <= '0;
      wval_q   <= '0;
      mask_q   <= '0;
      rx_dat_q <= '0;
      rx_crc_q <= '0;
      rdata_q  <= '0;
      wr_ph_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= '0;
      wcnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(req_op_i);
          addr_q  <= req_addr_i;
          wval_q  <= req_wdata_i;
          mask_q  <= req_mask_i;
          wr_ph_q <= 1'b0;
          idx_q   <= '0;
          st_q    <= S_LOAD;
        end
        S_LOAD: st_q <= S_SHIFT;
        S_SHIFT: if (sh_done) begin
          if (rd_ph && idx_q == IW'(1)) rx_dat_q <= sh_rx;
          if (rd_ph && idx_q == IW'(2)) rx_crc_q <= sh_rx;
          if (idx_q == last_idx) begin
            st_q   <= S_GAP;
            wcnt_q <= '0;
          end else begin
            idx_q <= idx_q + IW'(1);
            st_q  <= S_LOAD;
          end
        end
        S_GAP: if (wcnt_q == WW'(GAP_CYC - 1)) begin
          wcnt_q <= '0;
          unique case (op_q)
            OP_SRST: st_q <= S_WAIT;
            OP_WR: begin
              st_q <= S_IDLE; done_q <= 1'b1; rdata_q <= '0; err_q <= 1'b0;
            end
            OP_RD: begin
              st_q <= S_IDLE; done_q <= 1'b1; rdata_q <= rx_dat_q; err_q <= crc_bad;
            end
            default: begin
              if (wr_ph_q) begin
                st_q <= S_IDLE; done_q <= 1'b1; rdata_q <= rx_dat_q; err_q <= 1'b0;
              end else if (crc_bad || merged == rx_dat_q) begin
                st_q <= S_IDLE; done_q <= 1'b1; rdata_q <= rx_dat_q; err_q <= crc_bad;
              end else begin
                wval_q  <= merged;
                wr_ph_q <= 1'b1;
                idx_q   <= '0;
                st_q    <= S_LOAD;
              end
            end
          endcase
        end else begin
          wcnt_q <= wcnt_q + WW'(1);
        end
        S_WAIT: if (wcnt_q == WW'(RST_WAIT_CYC - 1)) begin
          st_q <= S_IDLE; done_q <= 1'b1; rdata_q <= '0; err_q <= 1'b0;
        end else begin
          wcnt_q <= wcnt_q + WW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign busy_o      = !req_ready_o;
  assign cs_no       = !(st_q == S_LOAD || st_q == S_SHIFT);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign crc_err_o   = err_q;
endmodule

// File: rtl/spi_regacc_chk.sv
module spi_regacc_chk
  import spi_regacc_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned GAP_SCLK = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_op_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       crc_err_o,
  input logic       sclk_o,
  input logic       cs_no,
  input logic       mosi_o
);
  localparam int unsigned GAP_CYC = GAP_SCLK * 2 * CLK_DIV;

  logic        sclk_q;
  logic [15:0] run_q, hi_q;
  logic [1:0]  op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      run_q  <= '0;
      hi_q   <= 16'hFFFF;
      op_q   <= 2'd0;
    end else begin
      sclk_q <= sclk_o;
      if (sclk_o != sclk_q)    run_q <= 16'd1;
      else if (run_q != '1)    run_q <= run_q + 16'd1;
      if (!cs_no)              hi_q <= '0;
      else if (hi_q != '1)     hi_q <= hi_q + 16'd1;
      if (req_valid_i && req_ready_o) op_q <= req_op_i;
    end
  end

  p_sclk_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_sclk_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && !sclk_o) |-> run_q == 16'(CLK_DIV));
  p_cs_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> hi_q >= 16'(GAP_CYC));
  p_frame_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  p_no_ready_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_no));
  p_wr_noerr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_WR || op_q == OP_SRST)) |-> !crc_err_o);
  p_rst_mosi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && op_q == OP_SRST) |-> mosi_o);
endmodule

bind spi_regacc spi_regacc_chk #(.CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_op_i    (req_op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .crc_err_o   (crc_err_o),
  .sclk_o      (sclk_o),
  .cs_no       (cs_no),
  .mosi_o      (mosi_o)
);

// File: tb/spi_regacc_bench.sv
module spi_regacc_bench;
  localparam int DIV = 3;
  localparam int RW  = 400;
  localparam int GAP = 2 * 2 * DIV;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0, req_mask = '0;
  logic       req_ready, busy, done, crc_err, sclk, cs_n, mosi;
  logic [7:0] rdata;
  logic       miso = 1'b0;

  spi_regacc #(.CLK_DIV(DIV), .GAP_SCLK(2), .RST_WAIT_CYC(RW)) u_spi_regacc (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_mask_i(req_mask), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .crc_err_o(crc_err), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  always #4 clk = ~clk;

  int nvec = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  function automatic [7:0] crcf(input [7:0] a, input [7:0] b);
    logic [7:0] c;
    c = 8'h00;
    for (int k = 0; k < 2; k++) begin
      c ^= (k == 0) ? a : b;
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  // device model state
  logic [7:0]  mem [128];
  logic [7:0]  corrupt = 8'h00;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;
  int nb = 0, wr_cnt = 0, rst_cnt = 0, frame_cnt = 0, rise_cyc = -100000;

  // expectation shared by driver
  int         exp_bits = 24, op_frame0 = 0;
  logic [1:0] exp_op = 2'd0;
  logic [6:0] exp_addr = '0;
  bit         exp_srst = 0;

  initial for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);

  always @(negedge cs_n) begin
    chk("R10 cs high gap", 64'(cyc - rise_cyc >= GAP), 64'd1);
    nb   = 0;
    cap  = '0;
    miso = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) begin
    cap = {cap[62:0], mosi};
    nb++;
  end

  always @(negedge sclk) if (!cs_n) begin
    if (nb == 8) resp = {mem[cap[6:0]], crcf(cap[7:0], mem[cap[6:0]]) ^ corrupt};
    if (nb >= 8 && nb < 24) miso = resp[15 - (nb - 8)];
    else miso = 1'b0;
  end

  always @(posedge cs_n) if (nb > 0) begin
    logic [7:0] b0, b1, b2;
    bit exp_rd;
    rise_cyc = cyc;
    chk("R2 R4 frame length", 64'(nb), 64'(exp_bits));
    if (nb == 64) begin
      chk("R8 reset pattern all ones", cap, 64'hFFFF_FFFF_FFFF_FFFF);
      rst_cnt++;
    end else begin
      if (nb == 24) begin b0 = cap[23:16]; b1 = cap[15:8]; b2 = cap[7:0];
        chk("R3 check byte", 64'(b2), 64'(crcf(b0, b1)));
      end else begin b0 = cap[15:8]; b1 = cap[7:0]; end
      exp_rd = (exp_op == 2'd1) || (exp_op == 2'd2 && frame_cnt == op_frame0);
      chk("R1 command read bit", 64'(b0[7]), 64'(exp_rd));
      chk("R1 command address", 64'(b0[6:0]), 64'(exp_addr));
      if (!b0[7]) begin mem[b0[6:0]] = b1; wr_cnt++; end
      else chk("R2 read data byte zero", 64'(b1), 64'd0);
    end
    frame_cnt++;
  end

  // scoreboard
  logic [8:0] q[$];
  int done_cnt = 0;
  always @(negedge clk) if (rst_n && done) begin
    logic [8:0] e;
    if (q.size() == 0) chk("R12 unexpected done", 64'd1, 64'd0);
    else begin
      e = q.pop_front();
      chk("R5 R6 R12 rdata", 64'(rdata), 64'(e[7:0]));
      chk("R5 R7 R12 crc_err", 64'(crc_err), 64'(e[8]));
      chk("R12 busy low at done", 64'(busy), 64'd0);
    end
    if (exp_srst) chk("R8 reset wait", 64'(cyc - rise_cyc >= RW), 64'd1);
    done_cnt++;
  end

  task automatic do_op(input logic [1:0] op, input logic [6:0] a, input logic [7:0] wd,
                       input logic [7:0] mk, input bit junk);
    logic [7:0] old, nw;
    bit bad, ew;
    int d0, w0, r0;
    while (!req_ready) @(negedge clk);
    old = mem[a];
    nw  = (old & ~mk) | (wd & mk);
    bad = (corrupt != 0) && (a != 7'h5A) && (op == 2'd1 || op == 2'd2);
    ew  = (op == 2'd0) || (op == 2'd2 && !bad && nw != old);
    case (op)
      2'd1, 2'd2: q.push_back({bad, old});
      default:    q.push_back(9'h000);
    endcase
    exp_bits  = (op == 2'd3) ? 64 : (a == 7'h5A) ? 16 : 24;
    exp_op    = op;
    exp_addr  = a;
    exp_srst  = (op == 2'd3);
    op_frame0 = frame_cnt;
    d0 = done_cnt; w0 = wr_cnt; r0 = rst_cnt;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_mask = mk;
    @(negedge clk);
    if (junk) begin
      req_op = 2'd0; req_addr = 7'h33; req_wdata = 8'h99;
      for (int i = 0; i < 10; i++) begin
        chk("R11 ready low while busy", 64'(req_ready), 64'd0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    chk("R6 R7 write frame count", 64'(wr_cnt - w0), 64'(ew));
    if (op == 2'd0) chk("R2 written value", 64'(mem[a]), 64'(wd));
    if (op == 2'd2) chk("R6 register after rmw", 64'(mem[a]), 64'(ew ? nw : old));
    if (op == 2'd3) chk("R8 reset frame seen", 64'(rst_cnt - r0), 64'd1);
    if (junk) begin
      repeat (20) @(negedge clk);
      chk("R11 request while busy ignored", 64'(done_cnt - d0), 64'd1);
      chk("R11 ignored write left register", 64'(mem[7'h33]), 64'(8'(51 * 37 + 5)));
    end
    exp_srst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset cs high", 64'(cs_n), 64'd1);
    chk("R9 reset sclk low", 64'(sclk), 64'd0);
    chk("R11 reset busy low", 64'(busy), 64'd0);
    chk("R12 reset done low", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", 64'(req_ready), 64'd1);

    do_op(2'd1, 7'h10, 8'h00, 8'h00, 0);   // R1 R2 read
    do_op(2'd1, 7'h7F, 8'h00, 8'h00, 0);
    do_op(2'd1, 7'h00, 8'h00, 8'h00, 0);
    do_op(2'd0, 7'h22, 8'hA5, 8'h00, 1);   // R11 write with request while busy
    do_op(2'd1, 7'h22, 8'h00, 8'h00, 0);
    do_op(2'd0, 7'h5A, 8'h3C, 8'h00, 0);   // R4 short write
    do_op(2'd1, 7'h5A, 8'h00, 8'h00, 0);   // R4 short read
    corrupt = 8'h01;
    do_op(2'd1, 7'h10, 8'h00, 8'h00, 0);   // R5 mismatch
    do_op(2'd1, 7'h5A, 8'h00, 8'h00, 0);   // R4 no check
    do_op(2'd2, 7'h40, 8'hFF, 8'h0F, 0);   // R7 skip write on error
    corrupt = 8'h00;
    do_op(2'd2, 7'h40, 8'hF0, 8'hFF, 0);   // R6 changed
    do_op(2'd2, 7'h40, 8'hF0, 8'hFF, 0);   // R6 unchanged
    do_op(2'd2, 7'h41, 8'h00, 8'h00, 0);   // R6 empty mask
    do_op(2'd2, 7'h5A, 8'h81, 8'hC3, 0);   // R4 R6 short rmw
    do_op(2'd3, 7'h00, 8'h00, 8'h00, 0);   // R8 software reset
    do_op(2'd1, 7'h40, 8'h00, 8'h00, 0);
    repeat (10) @(negedge clk);
    chk("R12 scoreboard drained", 64'(q.size()), 64'd0);
    summary();
  end
endmodule